// File: doc/BRIEF.md
# Optical Transceiver Control/Status Sequencer

This block sits between the pins of an optical transceiver module and its management register space. It combines a hardware transmit-disable pin with a host-writable software disable and produces the one disable level that the transmitter driver uses. It also assembles an 8-bit status/control byte for the host, and it raises two readiness indications (serial bus usable, monitoring data valid) at fixed times after power-up.

All timing is counted in ticks. A tick is a single-cycle pulse that occurs once every `TICK_DIV` clock cycles, with the phase counted from reset release. This lets real millisecond intervals shrink to a few cycles in simulation. The transmitter is switched off as soon as either disable source asks for it. It is switched back on only after a quiet period of `TXON_TICKS` ticks with no disable request. The same rule applies to the power-on enable. The pin and signal-detect inputs are asynchronous and pass through two-flop synchronizers.

Status byte layout (bit: meaning): 7 synchronized disable pin (1 = asserted); 6 software disable (read/write); 5 reserved, reads 0; 4 constant 1; 3 scratch bit (read/write, no effect); 2 constant 0; 1 inverted synchronized signal detect (0 = signal present); 0 active-low data-ready.

Top module: `xcvr_ctl_seq`

## Requirements
- R1: While reset is held and after it is released, software disable and scratch bit are 0, `tx_disable_eff` is 1, `bus_ready` and `data_ready` are 0, and the status byte reads 0x93 (pin synchronizer resets to asserted, signal-detect synchronizer to absent).
- R2: `tx_disable_eff` is 1 whenever the synchronized pin or the software disable (bit 6) is 1. A write with bit 6 set raises it in the cycle after the write edge.
- R3: Bit 7 equals the disable pin and bit 1 equals the inverse of signal detect, each two clock edges after the input changes.
- R4: Bit 5 always reads 0, bit 4 always reads 1, and bit 2 always reads 0. Writes to bits 7, 5, 4, 2, 1 and 0 are discarded.
- R5: Bit 3 stores the written value and reads it back. It has no effect on `tx_disable_eff`.
- R6: `bus_ready` rises after exactly `BUS_TICKS*TICK_DIV` clock edges from reset release and then stays 1.
- R7: `data_ready` rises and bit 0 falls after exactly `DATA_TICKS*TICK_DIV` edges from reset release (`DATA_TICKS >= BUS_TICKS`), and both then hold.
- R8: `tx_disable_eff` falls only after `TXON_TICKS` tick pulses with no disable request. With the pin low at power-up, it falls after exactly `TXON_TICKS*TICK_DIV` edges.
- R9: With `wr_en` low, `wr_data` changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset (power-on) |
| txdis_pin | input | 1 | Asynchronous hardware transmit-disable pin, 1 = disable |
| sig_det | input | 1 | Asynchronous signal-detect level, 1 = light present |
| wr_en | input | 1 | Host write strobe for the status/control byte |
| wr_data | input | 8 | Host write data |
| tx_disable_eff | output | 1 | Effective transmitter disable, 1 = off |
| ctl_byte | output | 8 | Status/control byte read value |
| bus_ready | output | 1 | Serial bus usable |
| data_ready | output | 1 | Monitoring data valid (active high) |

## Verification
The bench writes all-ones and all-zeros patterns. A design that stored the reserved or fixed bits, or that let the pin and signal-detect mirrors be overwritten, would then read back a wrong byte. It sets the pin and the software disable both alone and together, and it sets the scratch bit alone. This catches an AND in place of the OR, or a scratch bit that gates the transmitter. It measures the exact edge counts to bus-ready, data-ready and the power-on enable, so an off-by-one tick or a swapped threshold shows up as a wrong count. It also bounds the re-enable delay after each disable source is released, which catches a transmitter that turns back on immediately.

// File: rtl/xcs_pkg.sv
// Package: bit positions of the status/control byte shared by the sequencer.
// Assumes an 8-bit byte; positions are fixed because host software decodes them.
package xcs_pkg;
    localparam int B_PIN     = 7;
    localparam int B_SOFT    = 6;
    localparam int B_RSVD    = 5;
    localparam int B_ONE     = 4;
    localparam int B_SCRATCH = 3;
    localparam int B_ZERO    = 2;
    localparam int B_SDN     = 1;
    localparam int B_RDYN    = 0;
endpackage

// File: rtl/xcs_sync2.sv
// Two-flop synchronizer, W bits wide, reset to RST_VAL.
// Assumes inputs are level signals that hold for several clocks.
module xcs_sync2 #(
    parameter int W = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // Two-stage capture of the asynchronous inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= RST_VAL;
            q    <= RST_VAL;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/xcs_timebase.sv
// Tick divider plus a saturating power-up tick counter. It drives the bus-ready
// and data-ready levels. Assumes TICK_DIV >= 2 and DATA_TICKS >= BUS_TICKS >= 1.
module xcs_timebase #(
    parameter int TICK_DIV   = 100000,
    parameter int BUS_TICKS  = 250,
    parameter int DATA_TICKS = 900
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick,
    output logic bus_ready,
    output logic data_ready
);
    localparam int DW = $clog2(TICK_DIV);
    localparam int UW = $clog2(DATA_TICKS + 1);
    localparam logic [DW-1:0] DIV_LAST = DW'(TICK_DIV - 1);
    localparam logic [UW-1:0] BUS_V    = UW'(BUS_TICKS);
    localparam logic [UW-1:0] DATA_V   = UW'(DATA_TICKS);

    logic [DW-1:0] div_cnt;
    logic [UW-1:0] up_cnt;

    assign tick = (div_cnt == DIV_LAST);

    // Free-running divider that marks one tick every TICK_DIV cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)    div_cnt <= '0;
        else if (tick) div_cnt <= '0;
        else           div_cnt <= div_cnt + 1'b1;
    end

    // Ticks since power-up, saturating at the data-ready threshold.
    always_ff @(posedge clk) begin
        if (!rst_n)                       up_cnt <= '0;
        else if (tick && up_cnt < DATA_V) up_cnt <= up_cnt + 1'b1;
    end

    assign bus_ready  = (up_cnt >= BUS_V);
    assign data_ready = (up_cnt >= DATA_V);

    a_r6_bus_holds: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ready |=> bus_ready);
    a_r7_data_after_bus: assert property (@(posedge clk) disable iff (!rst_n)
        data_ready |-> bus_ready);
    a_r7_data_holds: assert property (@(posedge clk) disable iff (!rst_n)
        data_ready |=> data_ready);
endmodule

// File: rtl/xcs_tx_gate.sv
// Transmitter gate. Any disable request turns it off at once. It turns back on
// after TXON_TICKS tick pulses pass with no request. It starts off at reset, so
// the power-on enable obeys the same hold-off.
module xcs_tx_gate #(
    parameter int TXON_TICKS = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic req,
    output logic tx_off
);
    localparam int CW = $clog2(TXON_TICKS + 1);
    localparam logic [CW-1:0] ON_V = CW'(TXON_TICKS);

    logic [CW-1:0] quiet;

    // Counts quiet ticks; any request restarts the count.
    always_ff @(posedge clk) begin
        if (!rst_n || req)              quiet <= '0;
        else if (tick && quiet < ON_V)  quiet <= quiet + 1'b1;
    end

    assign tx_off = req | (quiet < ON_V);

    a_r8_no_early_on: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_off) |-> $past(!req));
endmodule

// File: rtl/xcvr_ctl_seq.sv
// Top of the transceiver control/status sequencer. It synchronizes the pins,
// holds the writable bits, assembles the status byte and instantiates the
// timebase and the transmitter gate. Assumes a synchronous active-low power-on reset.
module xcvr_ctl_seq #(
    parameter int TICK_DIV   = 100000,
    parameter int BUS_TICKS  = 250,
    parameter int DATA_TICKS = 900,
    parameter int TXON_TICKS = 50
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       txdis_pin,
    input  logic       sig_det,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic       tx_disable_eff,
    output logic [7:0] ctl_byte,
    output logic       bus_ready,
    output logic       data_ready
);
    import xcs_pkg::*;

    logic [1:0] pins_s;
    logic       soft_dis, scratch, tick;

    xcs_sync2 #(.W(2), .RST_VAL(2'b10)) i_sync (
        .clk(clk), .rst_n(rst_n), .d({txdis_pin, sig_det}), .q(pins_s));

    // Writable bits: the soft disable and the scratch bit only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            soft_dis <= 1'b0;
            scratch  <= 1'b0;
        end else if (wr_en) begin
            soft_dis <= wr_data[B_SOFT];
            scratch  <= wr_data[B_SCRATCH];
        end
    end

    xcs_timebase #(.TICK_DIV(TICK_DIV), .BUS_TICKS(BUS_TICKS),
                   .DATA_TICKS(DATA_TICKS)) i_tb (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .bus_ready(bus_ready), .data_ready(data_ready));

    xcs_tx_gate #(.TXON_TICKS(TXON_TICKS)) i_gate (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .req(pins_s[1] | soft_dis), .tx_off(tx_disable_eff));

    // Assemble the byte with the mixed-polarity mirrors and the fixed bits.
    always_comb begin
        ctl_byte            = '0;
        ctl_byte[B_PIN]     = pins_s[1];
        ctl_byte[B_SOFT]    = soft_dis;
        ctl_byte[B_RSVD]    = 1'b0;
        ctl_byte[B_ONE]     = 1'b1;
        ctl_byte[B_SCRATCH] = scratch;
        ctl_byte[B_ZERO]    = 1'b0;
        ctl_byte[B_SDN]     = ~pins_s[0];
        ctl_byte[B_RDYN]    = ~data_ready;
    end

    a_r2_soft_write_disables: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_data[B_SOFT] |=> tx_disable_eff);
    a_r2_pin_disables: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_byte[B_PIN] |-> tx_disable_eff);
    a_r9_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(ctl_byte[B_SCRATCH]) && $stable(ctl_byte[B_SOFT]));
    a_r7_ready_bit_matches: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctl_byte[B_RDYN]) |-> $rose(data_ready));
endmodule

// File: tb/test_xcvr_ctl_seq.sv
module test_xcvr_ctl_seq;
    localparam int DIV = 4, BUS = 3, DATA = 5, ON = 2;

    logic clk = 0, rst_n = 0, pin = 0, sd = 1, wen = 0;
    logic [7:0] wd = 0;
    logic txd, busr, datr;
    logic [7:0] cb;
    int checks = 0, fails = 0;

    always #2.5 clk = ~clk;

    xcvr_ctl_seq #(.TICK_DIV(DIV), .BUS_TICKS(BUS), .DATA_TICKS(DATA),
                   .TXON_TICKS(ON)) i_xcvr_ctl_seq (
        .clk(clk), .rst_n(rst_n), .txdis_pin(pin), .sig_det(sd), .wr_en(wen),
        .wr_data(wd), .tx_disable_eff(txd), .ctl_byte(cb),
        .bus_ready(busr), .data_ready(datr));

    // {pin, sd, wen, wdata, expected byte, expected tx_disable_eff}
    typedef struct packed {
        logic p; logic s; logic w; logic [7:0] d; logic [7:0] eb; logic et;
    } vec_t;
    localparam vec_t VT [8] = '{
        '{1'b0, 1'b1, 1'b1, 8'h00, 8'h10, 1'b0},
        '{1'b0, 1'b1, 1'b1, 8'hFF, 8'h58, 1'b1},
        '{1'b1, 1'b1, 1'b0, 8'h00, 8'hD8, 1'b1},
        '{1'b1, 1'b0, 1'b1, 8'h00, 8'h92, 1'b1},
        '{1'b0, 1'b0, 1'b1, 8'h08, 8'h1A, 1'b0},
        '{1'b0, 1'b1, 1'b1, 8'h40, 8'h50, 1'b1},
        '{1'b0, 1'b1, 1'b1, 8'hBF, 8'h18, 1'b0},
        '{1'b0, 1'b1, 1'b0, 8'h40, 8'h18, 1'b0}};

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic edges(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
    endtask

    // Counts edges until sig equals val; returns the count (cap 1000).
    task automatic count_until(input int which, input logic val, output int n);
        n = 0;
        while (n < 1000) begin
            @(posedge clk); #1; n++;
            if ((which == 0 ? busr : which == 1 ? datr : txd) === val) break;
        end
    endtask

    initial begin
        #200000;
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int n;
        edges(3);
        // R1 reset state while held
        chk("R1 byte", cb, 8'h93); chk("R1 tx", txd, 1); chk("R1 bus", busr, 0);
        chk("R1 data", datr, 0);
        @(negedge clk); rst_n = 1;
        // R6 / R7 / R8 exact power-on edge counts
        fork
            begin int a; count_until(0, 1, a); chk("R6 bus edges", a, BUS*DIV); end
            begin int b; count_until(1, 1, b); chk("R7 data edges", b, DATA*DIV); end
            begin int c; count_until(2, 0, c); chk("R8 poweron edges", c, ON*DIV); end
        join
        chk("R7 ready bit low", cb[0], 0);
        edges(10);
        chk("R6 bus holds", busr, 1); chk("R7 data holds", datr, 1);

        // vector table: R2 R3 R4 R5 R9
        foreach (VT[k]) begin
            @(negedge clk);
            pin = VT[k].p; sd = VT[k].s; wen = VT[k].w; wd = VT[k].d;
            @(negedge clk); wen = 0;
            edges(ON*DIV + 6);
            chk($sformatf("R2/R3/R4/R5/R9 byte vec%0d", k), cb, VT[k].eb);
            chk($sformatf("R2/R5 tx vec%0d", k), txd, VT[k].et);
        end

        // R2: soft write takes effect in the cycle after the write edge
        @(negedge clk); wen = 1; wd = 8'h40;
        @(posedge clk); #1; wen = 0;
        chk("R2 soft immediate", txd, 1);
        // R8: release of soft disable waits ON ticks
        @(negedge clk); wen = 1; wd = 8'h00;
        @(posedge clk); #1; wen = 0;
        chk("R8 still off after soft release", txd, 1);
        count_until(2, 0, n);
        chk("R8 soft release window", (n >= (ON-1)*DIV - 1 && n <= ON*DIV + 1), 1);
        // R3: pin mirror takes two edges; R8 pin release window
        @(negedge clk); pin = 1;
        @(posedge clk); #1; chk("R3 pin not yet", cb[7], 0);
        @(posedge clk); #1; chk("R3 pin after 2", cb[7], 1);
        chk("R2 pin disables", txd, 1);
        edges(3);
        @(negedge clk); pin = 0;
        count_until(2, 0, n);
        chk("R8 pin release window", (n >= 2 + (ON-1)*DIV && n <= 2 + ON*DIV + 1), 1);
        // R3: signal-detect inverse mirror latency
        @(negedge clk); sd = 0;
        @(posedge clk); #1; chk("R3 sd not yet", cb[1], 0);
        @(posedge clk); #1; chk("R3 sd inverted", cb[1], 1);
        // R1: reapplied reset clears writable bits
        @(negedge clk); wen = 1; wd = 8'h48;
        @(negedge clk); wen = 0; rst_n = 0; sd = 1;
        edges(2);
        chk("R1 byte after reset", cb, 8'h93); chk("R1 tx after reset", txd, 1);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule